// File: doc/BRIEF.md
# Parallel Rate-1/2 Convolutional Encoder

This block encodes a stream of scrambled data bits into a rate-1/2 convolutional code. Each input bit produces two coded bits. The code has constraint length 7 and uses generator polynomials 133 and 171 (octal). A parameter sets how many input bits go in per clock, so each accepted group of `UNROLL` bits produces `2*UNROLL` coded bits in the same transfer. The serial shift-register encoder is unrolled into a chain of lanes. Each lane sees the encoder state as updated by the lanes before it in the same group.

Input and output both use valid/ready handshakes. One output register sits between them. A start-of-packet flag travels with the first group of every packet and clears the six-bit history before that group is encoded. The coded stream goes out unpunctured, as the lowest data rates need.

Top module: `conv_enc_par`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0.
- R2: Each coded pair is computed over a 7-bit window. Bit 6 of the window is the current input bit and bit 6-k is the input bit k positions earlier. Coded bit A is the XOR of the window bits selected by mask 7'o133. Coded bit B is the XOR of the window bits selected by mask 7'o171.
- R3: Input bit i of `in_data` (bit 0 first in time) yields `out_data[2i]` = A and `out_data[2i+1]` = B.
- R4: Inside one group, bit i is encoded with a history that already includes bits 0 to i-1 of that group.
- R5: The history carries across accepted groups of the same packet. After a group is accepted, the newest history bit equals that group's bit `UNROLL-1`.
- R6: A group accepted with `in_sop` = 1 is encoded from an all-zero history. An all-zero group accepted with `in_sop` = 1 therefore yields all-zero coded bits.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: `in_ready` = 1 exactly when the output register is empty or is being drained in this cycle. A group accepted in cycle n appears on `out_data` with `out_valid` = 1 in cycle n+1.
- R9: A cycle without acceptance, because `in_valid` = 0 or `in_ready` = 0, leaves the history unchanged whatever `in_data` and `in_sop` hold. The next coded output shows this.
- R10: R2 through R9 hold for any `UNROLL` of 1 or more, and are checked for widths 1, 3 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group offered |
| in_ready | output | 1 | Encoder can take a group this cycle |
| in_sop | input | 1 | Group starts a packet; clears history |
| in_data | input | UNROLL | Data bits, bit 0 earliest |
| out_valid | output | 1 | Coded group held on `out_data` |
| out_ready | input | 1 | Downstream takes the coded group |
| out_data | output | 2*UNROLL | Coded pairs, A at even and B at odd positions |

## Verification
The checker assumes `in_data` and `in_sop` are known whenever `in_valid` is high. It makes no assumption about them while `in_valid` is low. It also assumes `out_ready` can change freely in any cycle. The stimulus drives random garbage on data and start flag during idle and stalled cycles, so the ignore rules are exercised. It toggles `out_ready` randomly to create back-pressure. It inserts an all-zero packet start so the history clear becomes visible at the outputs.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
  localparam int unsigned CL = 7;
  localparam int unsigned SW = CL - 1;
  localparam logic [CL-1:0] GEN_A = 7'o133;
  localparam logic [CL-1:0] GEN_B = 7'o171;

  typedef logic [SW-1:0] cenc_state_t;

  // window: bit CL-1 = current bit, state bit SW-1 = newest past bit
  function automatic logic [CL-1:0] cenc_window(cenc_state_t s, logic b);
    return {b, s};
  endfunction

  // returns {B, A}
  function automatic logic [1:0] cenc_pair(logic [CL-1:0] w);
    return {^(w & GEN_B), ^(w & GEN_A)};
  endfunction

  function automatic cenc_state_t cenc_next(cenc_state_t s, logic b);
    return {b, s[SW-1:1]};
  endfunction
endpackage

// File: rtl/cenc_lane_chain.sv
module cenc_lane_chain
  import cenc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  cenc_state_t       seed,
  input  logic [W-1:0]      data,
  output logic [2*W-1:0]    coded,
  output cenc_state_t       state_out
);
  cenc_state_t st [0:W];

  assign st[0] = seed;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign coded[2*i +: 2] = cenc_pair(cenc_window(st[i], data[i]));
    assign st[i+1]         = cenc_next(st[i], data[i]);
  end

  assign state_out = st[W];
endmodule

// File: rtl/cenc_state_reg.sv
module cenc_state_reg
  import cenc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  cenc_state_t state_d,
  output cenc_state_t state_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '0;
    else if (load) state_q <= state_d;
  end
endmodule

// File: rtl/cenc_out_stage.sv
module cenc_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data_d,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= data_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_enc_par.sv
module conv_enc_par
  import cenc_pkg::*;
#(
  parameter int unsigned UNROLL = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sop,
  input  logic [UNROLL-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*UNROLL-1:0] out_data
);
  localparam int unsigned OW = 2 * UNROLL;

  logic          accept;
  cenc_state_t   state_q;
  cenc_state_t   seed;
  cenc_state_t   state_nx;
  logic [OW-1:0] coded;

  assign accept = in_valid && in_ready;
  assign seed   = in_sop ? '0 : state_q;

  cenc_lane_chain #(.W(UNROLL)) u_chain (
    .seed      (seed),
    .data      (in_data),
    .coded     (coded),
    .state_out (state_nx)
  );

  cenc_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .state_d (state_nx),
    .state_q (state_q)
  );

  cenc_out_stage #(.DW(OW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .data_d    (coded),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .can_take  (in_ready)
  );
endmodule

// File: rtl/cenc_checker.sv
module cenc_checker
  import cenc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_sop,
  input logic [W-1:0]   in_data,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_data,
  input cenc_state_t    state_q
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_state_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> state_q[SW-1] == $past(in_data[W-1]));

  p_idle_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(state_q));

  p_zero_sop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sop && (in_data == '0) |=> out_data == '0);
endmodule

bind conv_enc_par cenc_checker #(.W(UNROLL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sop    (in_sop),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .state_q   (state_q)
);

// File: tb/cenc_lane_tb.sv
module cenc_lane_tb #(
  parameter int unsigned W = 4,
  parameter int unsigned CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errors,
  output logic done
);
  logic           in_valid, in_ready, in_sop, out_valid, out_ready;
  logic [W-1:0]   in_data;
  logic [2*W-1:0] out_data;

  conv_enc_par #(.UNROLL(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // behavioural model: hist[k] = input bit k positions back
  bit             hist [1:6];
  bit             e_valid;
  logic [2*W-1:0] e_data;
  bit             garbage_seen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s width=%0d actual=%h expected=%h", tag, W, act, exp);
    end
  endtask

  task automatic encode(input logic [W-1:0] d, input logic sop, output logic [2*W-1:0] o);
    bit cur;
    if (sop) for (int k = 1; k <= 6; k++) hist[k] = 1'b0;
    for (int i = 0; i < W; i++) begin
      cur = d[i];
      o[2*i]   = cur ^ hist[2] ^ hist[3] ^ hist[5] ^ hist[6];
      o[2*i+1] = cur ^ hist[1] ^ hist[2] ^ hist[3] ^ hist[6];
      for (int k = 6; k >= 2; k--) hist[k] = hist[k-1];
      hist[1] = cur;
    end
  endtask

  initial begin
    logic           fire_in, fire_out, stalled, sop_grp;
    logic [2*W-1:0] coded;
    string          tag;
    checks = 0; errors = 0; done = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_data = '0; out_ready = 1'b0;
    e_valid = 1'b0; e_data = '0; garbage_seen = 1'b0;
    for (int k = 1; k <= 6; k++) hist[k] = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset", {31'd0, out_valid}, 32'd0);
    wait (rst_n);
    for (int c = 0; c < int'(CYCLES); c++) begin
      @(negedge clk);
      // effect of the edge just passed
      fire_in  = in_valid && (!e_valid || out_ready);
      fire_out = e_valid && out_ready;
      stalled  = e_valid && !out_ready;
      sop_grp  = in_sop;
      if (fire_in) begin
        encode(in_data, in_sop, coded);
        e_data  = coded;
        e_valid = 1'b1;
      end else if (fire_out) begin
        e_valid = 1'b0;
      end
      if (!fire_in && (in_valid || in_data != '0 || in_sop)) garbage_seen = 1'b1;
      chk(out_valid == e_valid, stalled ? "R7 hold valid" : "R8 out_valid",
          {31'd0, out_valid}, {31'd0, e_valid});
      if (e_valid) begin
        if (stalled)             tag = "R7 held data";
        else if (sop_grp)        tag = "R6 sop clear";
        else if (garbage_seen)   tag = "R9 ignored input";
        else                     tag = "R2 R3 R4 R5 coded data";
        chk(out_data == e_data, tag, 32'(out_data), 32'(e_data));
        if (fire_in) garbage_seen = 1'b0;
      end
      // next stimulus
      out_ready = (c < 40) ? 1'b1 : (($urandom % 4) != 0);
      if (c >= 60 && c < 66) begin
        in_valid = 1'b1; in_sop = (c == 60); in_data = '0; out_ready = 1'b1;
      end else begin
        in_valid = (c < 40) ? 1'b1 : (($urandom % 3) != 0);
        in_sop   = (c == 0) || (($urandom % 16) == 0);
        in_data  = W'($urandom);
      end
      #1;
      chk(in_ready == (!e_valid || out_ready), "R8 in_ready",
          {31'd0, in_ready}, {31'd0, (!e_valid || out_ready)});
    end
    done = 1'b1;
  end
endmodule

// File: tb/conv_enc_par_tb.sv
module conv_enc_par_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   ck1, er1, ck3, er3, ck8, er8;
  logic dn1, dn3, dn8;

  always #4 clk = ~clk;  // 125 MHz

  // R10: the same checks run for three unroll widths
  cenc_lane_tb #(.W(1)) u_lane_w1 (.clk(clk), .rst_n(rst_n), .checks(ck1), .errors(er1), .done(dn1));
  cenc_lane_tb #(.W(3)) u_lane_w3 (.clk(clk), .rst_n(rst_n), .checks(ck3), .errors(er3), .done(dn3));
  cenc_lane_tb #(.W(8)) u_lane_w8 (.clk(clk), .rst_n(rst_n), .checks(ck8), .errors(er8), .done(dn8));

  initial begin
    bit timeout;
    int total_ck, total_er;
    timeout = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      wait (dn1 && dn3 && dn8);
      begin repeat (20000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    total_ck = ck1 + ck3 + ck8;
    total_er = er1 + er3 + er8;
    if (timeout) begin
      total_ck++;
      total_er++;
      $display("FAIL R10 watchdog actual=timeout expected=all widths done");
    end
    $display("CHECKS %0d ERRORS %0d", total_ck, total_er);
    $finish;
  end
endmodule